// File: doc/BRIEF.md
# Power-Good Timeout Supervisor

This block produces the power-good (system reset release) level for a multi-channel supply controller. It watches a per-channel "output good" bit, a per-channel "input above threshold" bit, a global enable level and a per-channel participation mask. Once every condition has held without a break for a timeout, it raises power-good. When any threshold bit fails or the enable drops, power-good is cleared on the next clock edge.

The timeout in clock cycles is a fixed minimum set by a parameter plus a run-time extension taken from an input port. An active-low margin input suspends supervision for system-level testing. While margin is low, power-good and the registered fault line keep their current levels, and the timeout counter is frozen rather than cleared. When margin returns high, monitoring resumes from the frozen state. While margin is high, the fault line from the upstream tracking logic passes through a one-register hold stage.

Top module: `pgs_supervisor`

## Requirements
- R1: With margin high, power-good rises at the T-th consecutive clock edge at which the qualify condition holds. The qualify condition is: enable high, every threshold bit high, and every participating channel's output-good bit high. T = BASE_CYCLES + timeout_ext_i.
- R2: With margin high, a clock edge at which any threshold bit is low or enable is low drives power-good low after that edge.
- R3: If a participating channel's output-good bit is low at an edge, the timeout count restarts from zero. A channel whose ch_en_i bit is 0 is ignored entirely.
- R4: While margin_n_i is low, power-good and fault_n_o keep their levels whatever the other inputs do.
- R5: The timeout count is held, not cleared, across edges with margin_n_i low, and counting continues after margin returns high.
- R6: With margin high, fault_n_o equals the fault_n_i value sampled at the previous clock edge.
- R7: During reset, power-good is low and fault_n_o is high.
- R8: A nonzero timeout_ext_i lengthens the timeout by exactly that many edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_good_i | input | NUM_CH | Per-channel output above its good level |
| thr_ok_i | input | NUM_CH | Per-channel input above its undervoltage threshold |
| ch_en_i | input | NUM_CH | Per-channel participation mask (1 = supervised) |
| en_i | input | 1 | Global enable level |
| margin_n_i | input | 1 | Active-low margin: freezes outputs and counting |
| fault_n_i | input | 1 | Active-low fault line from the tracking logic |
| timeout_ext_i | input | CNT_W | Run-time timeout extension in cycles |
| pwr_good_o | output | 1 | Power-good level |
| fault_n_o | output | 1 | Held active-low fault output |

## Verification
Two events can arrive in the same cycle. A condition can fail exactly as margin falls, and an edge can complete the timeout just as an output-good bit drops. The directed cases put a threshold failure under an active margin and check that power-good survives the freeze. They then show the failure clearing power-good on the first edge after margin rises. Random stimulus toggles margin, enable, threshold and output-good bits together on many edges, and every cycle is compared against a bench reference that follows the requirement rules.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
   localparam int unsigned PGS_MAX_CH = 32;

   // Control bundle passed from qualification to the timer.
   typedef struct packed {
      logic cond_ok;   // all supervised conditions met this cycle
      logic run;       // monitoring active (margin not asserted)
   } pgs_ctl_t;
endpackage

// File: rtl/pgs_qualify.sv
module pgs_qualify
   import pgs_pkg::*;
#(
   parameter int unsigned NUM_CH = 3
) (
   input  logic [NUM_CH-1:0] out_good_i,
   input  logic [NUM_CH-1:0] thr_ok_i,
   input  logic [NUM_CH-1:0] ch_en_i,
   input  logic              en_i,
   input  logic              margin_n_i,
   output pgs_ctl_t          ctl_o
);
   logic [NUM_CH-1:0] ch_ok;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // A channel outside the mask never blocks power-good.
      assign ch_ok[c] = out_good_i[c] | ~ch_en_i[c];
   end

   always_comb begin
      ctl_o.cond_ok = en_i & (&thr_ok_i) & (&ch_ok);
      ctl_o.run     = margin_n_i;
   end
endmodule

// File: rtl/pgs_timer.sv
module pgs_timer
   import pgs_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned BASE_CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pgs_ctl_t         ctl_i,
   input  logic [CNT_W-1:0] ext_i,
   output logic             pg_o
);
   localparam int unsigned TW = CNT_W + 1;

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] cnt_inc;
   logic [TW-1:0] limit;
   logic          done;

   assign limit   = TW'(BASE_CYCLES) + {1'b0, ext_i};
   assign cnt_inc = cnt_q + TW'(1);
   assign done    = (cnt_inc >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pg_o  <= 1'b0;
      end else if (ctl_i.run) begin
         if (!ctl_i.cond_ok) begin
            cnt_q <= '0;
            pg_o  <= 1'b0;
         end else if (!pg_o) begin
            if (done) pg_o  <= 1'b1;
            else      cnt_q <= cnt_inc;
         end
      end
   end
endmodule

// File: rtl/pgs_hold.sv
module pgs_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic fault_n_i,
   output logic fault_n_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     fault_n_o <= 1'b1;
      else if (run_i) fault_n_o <= fault_n_i;
   end
endmodule

// File: rtl/pgs_supervisor.sv
module pgs_supervisor
   import pgs_pkg::*;
#(
   parameter int unsigned NUM_CH      = 3,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned BASE_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] out_good_i,
   input  logic [NUM_CH-1:0] thr_ok_i,
   input  logic [NUM_CH-1:0] ch_en_i,
   input  logic              en_i,
   input  logic              margin_n_i,
   input  logic              fault_n_i,
   input  logic [CNT_W-1:0]  timeout_ext_i,
   output logic              pwr_good_o,
   output logic              fault_n_o
);
   if (NUM_CH < 1 || NUM_CH > PGS_MAX_CH) begin : g_bad_ch
      $error("pgs_supervisor: NUM_CH out of range");
   end
   if (BASE_CYCLES < 1 || BASE_CYCLES >= (2 ** CNT_W)) begin : g_bad_base
      $error("pgs_supervisor: BASE_CYCLES must be 1..2**CNT_W-1");
   end

   pgs_ctl_t ctl;

   pgs_qualify #(.NUM_CH(NUM_CH)) u_qual (
      .out_good_i (out_good_i),
      .thr_ok_i   (thr_ok_i),
      .ch_en_i    (ch_en_i),
      .en_i       (en_i),
      .margin_n_i (margin_n_i),
      .ctl_o      (ctl)
   );

   pgs_timer #(.CNT_W(CNT_W), .BASE_CYCLES(BASE_CYCLES)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl_i (ctl),
      .ext_i (timeout_ext_i),
      .pg_o  (pwr_good_o)
   );

   pgs_hold u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (ctl.run),
      .fault_n_i (fault_n_i),
      .fault_n_o (fault_n_o)
   );
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
   parameter int unsigned NUM_CH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] out_good_i,
   input logic [NUM_CH-1:0] thr_ok_i,
   input logic [NUM_CH-1:0] ch_en_i,
   input logic              en_i,
   input logic              margin_n_i,
   input logic              fault_n_i,
   input logic              pwr_good_o,
   input logic              fault_n_o
);
   logic all_ok;
   assign all_ok = en_i && (&thr_ok_i) && (&(out_good_i | ~ch_en_i));

   // R1: a rise needs the full condition and margin high at the edge before
   p_rise_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_good_o) |-> $past(all_ok && margin_n_i));

   // R2: threshold or enable failure clears power-good
   p_fail_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (margin_n_i && !(en_i && (&thr_ok_i))) |=> !pwr_good_o);

   // R3: participating output drop clears power-good
   p_drop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (margin_n_i && !(&(out_good_i | ~ch_en_i))) |=> !pwr_good_o);

   // R4: margin freezes both outputs
   p_margin_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !margin_n_i |=> ($stable(pwr_good_o) && $stable(fault_n_o)));

   // R6: fault pass-through one cycle late
   p_fault_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      margin_n_i |=> (fault_n_o == $past(fault_n_i)));

   // R7: reset values
   p_reset_vals_r7: assert property (@(posedge clk)
      !rst_n |=> (!pwr_good_o && fault_n_o));
endmodule

bind pgs_supervisor pgs_checker #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_good_i (out_good_i),
   .thr_ok_i   (thr_ok_i),
   .ch_en_i    (ch_en_i),
   .en_i       (en_i),
   .margin_n_i (margin_n_i),
   .fault_n_i  (fault_n_i),
   .pwr_good_o (pwr_good_o),
   .fault_n_o  (fault_n_o)
);

// File: tb/sim_pgs_supervisor.sv
module sim_pgs_supervisor;
   localparam int unsigned NUM_CH = 3;
   localparam int unsigned CNT_W  = 8;
   localparam int unsigned BASE   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_CH-1:0] out_good = '0;
   logic [NUM_CH-1:0] thr_ok = '0;
   logic [NUM_CH-1:0] ch_en = '1;
   logic              en = 1'b0;
   logic              margin_n = 1'b1;
   logic              fault_n = 1'b1;
   logic [CNT_W-1:0]  ext = '0;
   logic              pg;
   logic              fault_n_q;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   pgs_supervisor #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .BASE_CYCLES(BASE)) u0 (
      .clk(clk), .rst_n(rst_n), .out_good_i(out_good), .thr_ok_i(thr_ok),
      .ch_en_i(ch_en), .en_i(en), .margin_n_i(margin_n), .fault_n_i(fault_n),
      .timeout_ext_i(ext), .pwr_good_o(pg), .fault_n_o(fault_n_q)
   );

   // Reference built from the requirement rules.
   int m_cnt;
   bit m_pg, m_fault;

   function automatic bit qual_ok();
      return en && (&thr_ok) && (&(out_good | ~ch_en));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_pg <= 0; m_fault <= 1;
      end else if (margin_n) begin
         m_fault <= fault_n;
         if (!qual_ok()) begin
            m_cnt <= 0; m_pg <= 0;
         end else if (!m_pg) begin
            if (m_cnt + 1 >= BASE + int'(ext)) m_pg <= 1;
            else m_cnt <= m_cnt + 1;
         end
      end
   end

   task automatic check(input bit got, input bit exp, input string req);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic all_good();
      out_good = '1; thr_ok = '1; en = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd1234);
      tick(3);
      check(pg, 1'b0, "R7 pg in reset");
      check(fault_n_q, 1'b1, "R7 fault in reset");
      rst_n = 1'b1;
      tick(1);

      // R1: exact boundary at BASE edges
      all_good();
      tick(BASE - 1);
      check(pg, 1'b0, "R1 one edge short");
      tick(1);
      check(pg, 1'b1, "R1 at timeout");

      // R2: threshold fail, then enable fail
      thr_ok[1] = 1'b0;
      tick(1);
      check(pg, 1'b0, "R2 threshold fail");
      all_good(); tick(BASE);
      check(pg, 1'b1, "R2 regain");
      en = 1'b0;
      tick(1);
      check(pg, 1'b0, "R2 enable low");

      // R3: drop mid-count restarts
      all_good(); tick(5);
      out_good[2] = 1'b0; tick(1);
      out_good[2] = 1'b1; tick(BASE - 1);
      check(pg, 1'b0, "R3 restart short");
      tick(1);
      check(pg, 1'b1, "R3 restart full");
      // R3: masked channel ignored
      en = 1'b0; tick(1);
      all_good(); ch_en = 3'b110; out_good = 3'b110;
      tick(BASE);
      check(pg, 1'b1, "R3 masked channel ignored");
      ch_en = '1; out_good = '1;

      // R4: freeze under margin with failing inputs
      margin_n = 1'b0; thr_ok = '0; en = 1'b0; fault_n = 1'b0;
      tick(5);
      check(pg, 1'b1, "R4 pg held");
      check(fault_n_q, 1'b1, "R4 fault held");
      margin_n = 1'b1;
      tick(1);
      check(pg, 1'b0, "R2 after margin release");
      check(fault_n_q, 1'b0, "R6 follows after release");

      // R6: pass-through
      fault_n = 1'b1; tick(1);
      check(fault_n_q, 1'b1, "R6 fault high");
      fault_n = 1'b0; tick(1);
      check(fault_n_q, 1'b0, "R6 fault low");
      fault_n = 1'b1;

      // R5: counter frozen across margin
      all_good(); tick(4);
      margin_n = 1'b0; thr_ok = '0; tick(10);
      check(pg, 1'b0, "R5 no rise in margin");
      margin_n = 1'b1; thr_ok = '1; tick(BASE - 5);
      check(pg, 1'b0, "R5 resumed short");
      tick(1);
      check(pg, 1'b1, "R5 resumed count kept");

      // R8: extension
      ext = 8'd5; en = 1'b0; tick(1);
      en = 1'b1; tick(BASE + 4);
      check(pg, 1'b0, "R8 extended short");
      tick(1);
      check(pg, 1'b1, "R8 extended full");

      // Random phase against the reference
      for (int i = 0; i < 3000; i++) begin
         for (int c = 0; c < NUM_CH; c++) begin
            out_good[c] = ($urandom_range(0, 40) != 0);
            thr_ok[c]   = ($urandom_range(0, 60) != 0);
            ch_en[c]    = ($urandom_range(0, 8) != 0);
         end
         en       = ($urandom_range(0, 50) != 0);
         fault_n  = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 15) == 0) margin_n = ~margin_n;
         if ($urandom_range(0, 200) == 0) ext = CNT_W'($urandom_range(0, 6));
         tick(1);
         check(pg, m_pg, margin_n ? "R1 random pg" : "R4 random pg");
         check(fault_n_q, m_fault, "R6 random fault");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule